// File: doc/BRIEF.md
# Acquisition Trigger and Sample Buffer Controller

This block decides when an analog-to-digital conversion begins and stores the converted results. A conversion can be started in one of three ways: by a software write strobe, by a rising edge of a pacer pulse, or by a rising edge of an external trigger pin. The external trigger can be gated by a second pin. Only one of these start sources may be enabled at a time. The converter itself sits outside the block. The block drives a one-cycle start pulse and receives each result as a done pulse together with its data.

Results go into a first-in first-out sample buffer, 4096 entries deep by default. The block reports empty, half-full and full flags and a sticky overrun flag. An interrupt can be raised on every completed conversion or once the buffer reaches half full. Two separate strobes clear the pending interrupt and empty the buffer. A single status word gives back the control settings in its low bits, next to the buffer and interrupt flags.

Top module: `acq_trig_fifo`

## Requirements
- R1: A control write is accepted only when at most one of the three start enables (bit0 software, bit1 pacer, bit2 external) is set. A write with two or more of them set is rejected, and the previous control value is kept. The other control bits are: bit3 gate qualify, bit4 interrupt on half-full (0 means on every conversion), bit5 interrupt enable, and bit6 counter clock select. `status[6:0]` and `ctr_clk_sel` reflect the accepted value.
- R2: Each `swtrig_wr` pulse produces exactly one `conv_start` pulse while the software enable is set. When that enable is clear, the pulse produces none.
- R3: With the pacer enable set, each low-to-high transition of `pacer_in` produces exactly one `conv_start` pulse. Holding the input high produces no further pulses.
- R4: With the external enable set, each rising edge of `ext_trig_in` produces one `conv_start` pulse. When gate qualify is set, an edge that arrives while `ext_gate_in` is low is blocked. When gate qualify is clear, the gate pin has no effect.
- R5: Samples presented with `conv_done` are returned on `rd_data` in arrival order. `rd_data` shows the oldest entry, and `rd_en` removes it.
- R6: `status[8]` is empty, `status[9]` is half-full (at least DEPTH/2 entries) and `status[10]` is full (DEPTH entries). After reset the status word reads 0x0100.
- R7: A sample that arrives while the buffer is full is discarded, and `status[12]` (overrun) is set and stays set.
- R8: With bit4 clear, every `conv_done` sets the pending flag (`status[11]`). `irq` equals pending AND the interrupt enable. `irq_clr_wr` clears pending.
- R9: With bit4 set, pending is set when the buffer fill level reaches DEPTH/2, and not before.
- R10: `fifo_clr_wr` empties the buffer and clears overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 7 | Control value |
| swtrig_wr | input | 1 | Software start strobe |
| irq_clr_wr | input | 1 | Clear pending interrupt |
| fifo_clr_wr | input | 1 | Empty the sample buffer |
| pacer_in | input | 1 | Asynchronous pacer pulse |
| ext_trig_in | input | 1 | Asynchronous external trigger |
| ext_gate_in | input | 1 | Asynchronous external gate |
| conv_start | output | 1 | One-cycle conversion start |
| conv_done | input | 1 | Conversion result valid |
| conv_data | input | DATA_W | Conversion result |
| rd_en | input | 1 | Remove oldest sample |
| rd_data | output | DATA_W | Oldest sample |
| status | output | 16 | Control echo and flags |
| irq | output | 1 | Interrupt request |
| ctr_clk_sel | output | 1 | Counter clock select bit |

## Verification
The bench checks that a control write with two or more start enables set is dropped. A design that took such a write would show several enables set at once in the status word. It counts start pulses for every source, including a held pacer level and gated external edges. A broken edge detector would then show extra pulses, and a broken gate would show missing pulses. It fills the buffer to exactly DEPTH/2 and then to DEPTH, and pushes one sample beyond full. An off-by-one flag, an interrupt raised at the wrong fill level, or a dropped sample that overwrites stored data would each show up as a wrong flag or a wrong value when the buffer is drained. It also checks that clearing the buffer removes the sticky overrun flag.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef struct packed {
    logic clk_sel;
    logic irq_en;
    logic irq_half;
    logic gate_en;
    logic ext_en;
    logic pacer_en;
    logic sw_en;
  } acq_ctrl_t;

  // at most one start source enabled
  function automatic logic ctrl_legal(acq_ctrl_t c);
    logic [1:0] n;
    n = {1'b0, c.sw_en} + {1'b0, c.pacer_en} + {1'b0, c.ext_en};
    return n <= 2'd1;
  endfunction

  function automatic logic [15:0] pack_status(acq_ctrl_t c, logic empty, logic half,
                                              logic full, logic pend, logic ovr);
    return {3'b000, ovr, pend, full, half, empty, 1'b0, c};
  endfunction
endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      end else begin
        s1 <= async_in[i]; s2 <= s1; s3 <= s2;
      end
    end
    assign level[i] = s2;
    assign rise[i]  = s2 & ~s3;
  end
endmodule

// File: rtl/acq_trig_sel.sv
module acq_trig_sel
  import acq_pkg::*;
(
  input  acq_ctrl_t ctrl,
  input  logic      sw_wr,
  input  logic      pacer_rise,
  input  logic      ext_rise,
  input  logic      gate_lvl,
  output logic      fire
);
  logic ext_ok;
  assign ext_ok = ext_rise & (~ctrl.gate_en | gate_lvl);
  assign fire   = (ctrl.sw_en & sw_wr) | (ctrl.pacer_en & pacer_rise) | (ctrl.ext_en & ext_ok);
endmodule

// File: rtl/acq_sample_fifo.sv
module acq_sample_fifo #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              half,
  output logic              full,
  output logic              overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign half    = (count >= HALF_CNT);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; overrun <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; overrun <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
      if (push && full) overrun <= 1'b1;
    end
  end

  // R6
  full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty));
  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr) |=> overrun);
  // R10
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !overrun));
endmodule

// File: rtl/acq_trig_fifo.sv
module acq_trig_fifo
  import acq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [6:0]        ctrl_wdata,
  input  logic              swtrig_wr,
  input  logic              irq_clr_wr,
  input  logic              fifo_clr_wr,
  input  logic              pacer_in,
  input  logic              ext_trig_in,
  input  logic              ext_gate_in,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [15:0]       status,
  output logic              irq,
  output logic              ctr_clk_sel
);
  acq_ctrl_t ctrl_q, ctrl_new;
  logic [2:0] lvl, rise;
  logic fire, f_empty, f_half, f_full, f_ovr;
  logic half_q, irq_set, pending;

  assign ctrl_new = acq_ctrl_t'(ctrl_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr && ctrl_legal(ctrl_new)) ctrl_q <= ctrl_new;
  end

  acq_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ext_gate_in, ext_trig_in, pacer_in}),
    .level(lvl), .rise(rise)
  );

  acq_trig_sel u_sel (
    .ctrl(ctrl_q), .sw_wr(swtrig_wr), .pacer_rise(rise[0]),
    .ext_rise(rise[1]), .gate_lvl(lvl[2]), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_start <= 1'b0;
    else        conv_start <= fire;
  end

  acq_sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr_wr),
    .push(conv_done), .push_data(conv_data), .pop(rd_en),
    .head(rd_data), .empty(f_empty), .half(f_half), .full(f_full), .overrun(f_ovr)
  );

  assign irq_set = ctrl_q.irq_half ? (f_half & ~half_q) : conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0; pending <= 1'b0;
    end else begin
      half_q <= f_half;
      if (irq_set)         pending <= 1'b1;
      else if (irq_clr_wr) pending <= 1'b0;
    end
  end

  assign irq         = pending & ctrl_q.irq_en;
  assign ctr_clk_sel = ctrl_q.clk_sel;
  assign status      = pack_status(ctrl_q, f_empty, f_half, f_full, pending, f_ovr);

  // R1
  src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status[2:0]) <= 1);
  // R8
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_wr && !irq_set) |=> !status[11]);
  // R2
  sw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swtrig_wr && status[0]) |=> conv_start);
endmodule

// File: tb/sim_acq_trig_fifo.sv
module sim_acq_trig_fifo;
  localparam int DW = 12;
  localparam int DEPTH = 4096;

  logic clk = 0, rst_n = 0;
  logic ctrl_wr = 0, swtrig_wr = 0, irq_clr_wr = 0, fifo_clr_wr = 0;
  logic [6:0] ctrl_wdata = 0;
  logic pacer_in = 0, ext_trig_in = 0, ext_gate_in = 0;
  logic conv_start, conv_done = 0, rd_en = 0, irq, ctr_clk_sel;
  logic [DW-1:0] conv_data = 0, rd_data;
  logic [15:0] status;

  int tests = 0, fails = 0, starts = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acq_trig_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (.*);

  always @(negedge clk) if (rst_n && conv_start) starts++;

  // {write value, expected echo}
  localparam logic [13:0] CTRL_VEC [9] = '{
    {7'h01, 7'h01}, {7'h03, 7'h01}, {7'h02, 7'h02}, {7'h06, 7'h02},
    {7'h07, 7'h02}, {7'h0C, 7'h0C}, {7'h05, 7'h0C}, {7'h70, 7'h70},
    {7'h00, 7'h00}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [6:0] v);
    ctrl_wdata = v; ctrl_wr = 1; cyc(1); ctrl_wr = 0; cyc(1);
  endtask

  task automatic strobe(ref logic s);
    s = 1; cyc(1); s = 0; cyc(1);
  endtask

  task automatic edges(ref logic s, input int n);
    for (int i = 0; i < n; i++) begin
      s = 1; cyc(3); s = 0; cyc(3);
    end
    cyc(4);
  endtask

  task automatic push_n(int n, int base);
    for (int i = 0; i < n; i++) begin
      conv_data = DW'(base + i); conv_done = 1; cyc(1);
    end
    conv_done = 0; cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int s0, bad;
    logic [DW-1:0] last;
    cyc(2); rst_n = 1; cyc(1);
    chk("R6 reset status", status, 16'h0100);
    chk("R8 reset irq", irq, 0);

    for (int i = 0; i < 9; i++) begin
      wr_ctrl(CTRL_VEC[i][13:7]);
      chk("R1 ctrl echo", status[6:0], CTRL_VEC[i][6:0]);
    end
    wr_ctrl(7'h41);
    chk("R1 clk sel", ctr_clk_sel, 1);

    // R2 software start
    s0 = starts;
    for (int i = 0; i < 3; i++) strobe(swtrig_wr);
    chk("R2 sw starts", starts - s0, 3);
    wr_ctrl(7'h02); s0 = starts;
    strobe(swtrig_wr);
    chk("R2 sw disabled", starts - s0, 0);

    // R3 pacer edges
    s0 = starts;
    edges(pacer_in, 4);
    chk("R3 pacer starts", starts - s0, 4);
    s0 = starts; pacer_in = 1; cyc(20); pacer_in = 0; cyc(5);
    chk("R3 held level", starts - s0, 1);

    // R4 external with gate
    wr_ctrl(7'h0C); ext_gate_in = 0; s0 = starts;
    edges(ext_trig_in, 3);
    chk("R4 gate low blocks", starts - s0, 0);
    ext_gate_in = 1; cyc(3); s0 = starts;
    edges(ext_trig_in, 3);
    chk("R4 gate high passes", starts - s0, 3);
    wr_ctrl(7'h04); ext_gate_in = 0; cyc(3); s0 = starts;
    edges(ext_trig_in, 2);
    chk("R4 gate ignored", starts - s0, 2);
    s0 = starts;
    edges(pacer_in, 2);
    chk("R3 pacer off in ext mode", starts - s0, 0);

    // R8 per-conversion interrupt
    wr_ctrl(7'h20);
    push_n(1, 12'h5A5);
    chk("R8 pending", status[11], 1);
    chk("R8 irq", irq, 1);
    strobe(irq_clr_wr);
    chk("R8 cleared", {status[11], irq}, 0);
    wr_ctrl(7'h00);
    push_n(1, 12'h123);
    chk("R8 masked irq", {status[11], irq}, 2'b10);
    strobe(irq_clr_wr);
    chk("R5 head", rd_data, 12'h5A5);
    rd_en = 1; cyc(1); rd_en = 0; cyc(1);
    chk("R5 next head", rd_data, 12'h123);
    strobe(fifo_clr_wr);
    chk("R10 cleared", status[12:8], 5'b00001);

    // R9 half-full interrupt, R6/R7 flags
    wr_ctrl(7'h30);
    push_n(DEPTH/2 - 1, 0); cyc(2);
    chk("R9 no irq below half", {status[11], status[9]}, 0);
    push_n(1, DEPTH/2 - 1); cyc(1);
    chk("R9 irq at half", {irq, status[11], status[9]}, 3'b111);
    push_n(DEPTH/2, DEPTH/2);
    chk("R6 full", status[10:8], 3'b110);
    chk("R7 no overrun yet", status[12], 0);
    push_n(1, 12'hFFF ^ 12'h001);
    chk("R7 overrun", status[12], 1);
    bad = 0; last = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd_en = 1;
      if (rd_data !== DW'(i)) bad++;
      last = rd_data;
      cyc(1);
    end
    rd_en = 0; cyc(1);
    chk("R5 drain order", bad, 0);
    chk("R7 last kept", last, 12'hFFF);
    chk("R6 empty after drain", status[10:8], 3'b001);
    chk("R7 overrun sticky", status[12], 1);
    strobe(fifo_clr_wr);
    chk("R10 overrun cleared", status[12], 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule